// File: doc/BRIEF.md
# Partitioned SIMD Add, Subtract and Compare Unit

This unit performs lane-wise arithmetic and signed comparison on 64-bit operands. Each operand is split into independent 16-bit or 32-bit lanes. Add and subtract produce a packed 64-bit data result. Compares produce a per-lane truth mask that lands in the low bits of an integer result word.

A reduced-width mode works on the low 32 bits only. In that mode the upper half of the data result is copied unchanged from the previous destination value, which the caller supplies on `dst_prev`. The caller presents the operands together with `in_valid`. The registered results appear one clock later, flagged by `out_valid`.

Top module: `simd_lane_alu`

## Requirements
- R1: With `lane32`=0 and `half_mode`=0, add (`op_sel`=000) and subtract (`op_sel`=001) operate on four independent 16-bit lanes. Each lane wraps modulo 2^16 and no carry or borrow crosses bit 16, 32 or 48.
- R2: With `lane32`=1 and `half_mode`=0, add and subtract operate on two 32-bit lanes (bits 31:0 and 63:32). Each lane wraps modulo 2^32 and carries do cross bits 16 and 48.
- R3: With `half_mode`=1, add and subtract work on bits 31:0 only: two 16-bit lanes, or one 32-bit lane when `lane32`=1. Bits 63:32 of `res_data` equal `dst_prev[63:32]`.
- R4: A compare sets one bit of `res_int` per active lane, with lane 0 (the least significant lane) in bit 0. That gives 4 bits for full 16-bit lanes, 2 for full 32-bit lanes, 2 for half 16-bit lanes and 1 for half 32-bit lanes. All bits above them are zero.
- R5: Compares treat lanes as signed two's-complement. The codes are `op_sel`=100 for greater-than (a>b), 101 for less-or-equal (a<=b), 110 for equal and 111 for not-equal. A mask bit is 1 when the relation holds for that lane.
- R6: Compare operations give `res_data` = `dst_prev`. Add and subtract give `res_int` = 0.
- R7: Results are registered with one cycle of latency, and `out_valid` is `in_valid` delayed by one cycle. While `in_valid` is low, `res_data` and `res_int` hold their values.
- R8: While `rst_n` is low, `out_valid`, `res_data` and `res_int` are all zero.
- R9: The reserved codes `op_sel`=010 and 011 give `res_data` = `dst_prev` and `res_int` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_sel | input | 3 | Operation code (see R1, R5, R9) |
| lane32 | input | 1 | 0 selects 16-bit lanes, 1 selects 32-bit lanes |
| half_mode | input | 1 | 1 restricts the operation to bits 31:0 |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand |
| dst_prev | input | 64 | Previous destination value |
| out_valid | output | 1 | Registered results are new this cycle |
| res_data | output | 64 | Packed lane result |
| res_int | output | 64 | Integer word holding the compare mask |

## Verification
Directed operands put all-ones patterns at every lane boundary. These separate 16-bit from 32-bit carry handling and expose any carry leaking between lanes. Compare vectors place values near the sign boundary, such as 0x7FFF against 0x8000, so that a signed compare can be told apart from an unsigned one. Equal and differing lane pairs set the equal and not-equal masks apart. A long run of random operands, modes and codes is then checked against a behavioural lane model, and it also covers the reduced-width upper-half copy and the reserved codes.

// File: rtl/simd_lane_pkg.sv
// Package: shared operation codes and the compare-relation selector.
// Assumes op_sel[2] marks a compare and op_sel[1:0] then picks the relation.
package simd_lane_pkg;
    localparam logic [2:0] OP_ADD = 3'b000;
    localparam logic [2:0] OP_SUB = 3'b001;
    localparam logic [2:0] OP_CGT = 3'b100;
    localparam logic [2:0] OP_CLE = 3'b101;
    localparam logic [2:0] OP_CEQ = 3'b110;
    localparam logic [2:0] OP_CNE = 3'b111;

    // Pick the relation result from greater-than and equal flags.
    function automatic logic rel_pick(input logic [1:0] kind, input logic gt, input logic eq);
        case (kind)
            2'b00:   rel_pick = gt;
            2'b01:   rel_pick = ~gt;
            2'b10:   rel_pick = eq;
            default: rel_pick = ~eq;
        endcase
    endfunction
endpackage

// File: rtl/simd_addsub.sv
// Module: partitioned adder/subtractor built from SUB_W-bit segments.
// Even segments start a lane. Odd segments take the carry of the segment
// below them only when wide lanes are selected. Assumes an even segment count.
module simd_addsub #(
    parameter int DATA_W = 64,
    parameter int SUB_W  = 16
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    input  logic              wide,
    output logic [DATA_W-1:0] sum
);
    localparam int NSUB = DATA_W / SUB_W;

    logic [NSUB/2-1:0] carry;

    for (genvar i = 0; i < NSUB; i++) begin : g_seg
        if (i % 2 == 0) begin : g_lo
            logic [SUB_W:0] t;
            // Low segment: carry-in is the subtract flag (two's-complement +1).
            assign t = {1'b0, a[i*SUB_W +: SUB_W]}
                     + {1'b0, b[i*SUB_W +: SUB_W] ^ {SUB_W{sub}}}
                     + {{SUB_W{1'b0}}, sub};
            assign sum[i*SUB_W +: SUB_W] = t[SUB_W-1:0];
            assign carry[i/2] = t[SUB_W];
        end else begin : g_hi
            logic cin;
            // High segment: chain to the low segment only for wide lanes.
            assign cin = wide ? carry[i/2] : sub;
            assign sum[i*SUB_W +: SUB_W] = a[i*SUB_W +: SUB_W]
                                         + (b[i*SUB_W +: SUB_W] ^ {SUB_W{sub}})
                                         + {{(SUB_W-1){1'b0}}, cin};
        end
    end
endmodule

// File: rtl/simd_compare.sv
// Module: signed lane comparator producing a per-lane truth mask.
// Computes narrow (SUB_W) and wide (2*SUB_W) results side by side and keeps
// only the active lanes. Lane 0 maps to mask bit 0 and unused bits are zero.
module simd_compare
    import simd_lane_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int SUB_W  = 16
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [1:0]        kind,
    input  logic              wide,
    input  logic              half,
    output logic [DATA_W/SUB_W-1:0] mask
);
    localparam int NSUB  = DATA_W / SUB_W;
    localparam int NWIDE = NSUB / 2;
    localparam int WW    = 2 * SUB_W;

    logic [NSUB-1:0]  m_nar;
    logic [NWIDE-1:0] m_wid;

    for (genvar i = 0; i < NSUB; i++) begin : g_nar
        logic gt, eq;
        // Narrow-lane signed relation, masked off above the half when reduced.
        assign gt = $signed(a[i*SUB_W +: SUB_W]) > $signed(b[i*SUB_W +: SUB_W]);
        assign eq = a[i*SUB_W +: SUB_W] == b[i*SUB_W +: SUB_W];
        assign m_nar[i] = rel_pick(kind, gt, eq) & (~half | (i < NSUB/2));
    end

    for (genvar j = 0; j < NWIDE; j++) begin : g_wid
        logic gt, eq;
        // Wide-lane signed relation, masked off above the half when reduced.
        assign gt = $signed(a[j*WW +: WW]) > $signed(b[j*WW +: WW]);
        assign eq = a[j*WW +: WW] == b[j*WW +: WW];
        assign m_wid[j] = rel_pick(kind, gt, eq) & (~half | (j < NWIDE/2));
    end

    // Select the lane-size variant and pack it into the low bits.
    assign mask = wide ? {{(NSUB-NWIDE){1'b0}}, m_wid} : m_nar;
endmodule

// File: rtl/simd_lane_alu.sv
// Module: top of the partitioned SIMD add/subtract/compare unit.
// Decodes the operation, merges the reduced-width result with the previous
// destination value, and registers both result words with one-cycle latency.
// Assumes DATA_W is a multiple of 4*SUB_W. The reset is synchronous, active low.
module simd_lane_alu
    import simd_lane_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int SUB_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        op_sel,
    input  logic              lane32,
    input  logic              half_mode,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [DATA_W-1:0] dst_prev,
    output logic              out_valid,
    output logic [DATA_W-1:0] res_data,
    output logic [DATA_W-1:0] res_int
);
    localparam int NSUB   = DATA_W / SUB_W;
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] sum;
    logic [NSUB-1:0]   mask;
    logic [DATA_W-1:0] nxt_data, nxt_int;
    logic              is_arith, is_cmp;

    simd_addsub #(.DATA_W(DATA_W), .SUB_W(SUB_W)) u_addsub (
        .a(src_a), .b(src_b), .sub(op_sel == OP_SUB), .wide(lane32), .sum(sum)
    );

    simd_compare #(.DATA_W(DATA_W), .SUB_W(SUB_W)) u_cmp (
        .a(src_a), .b(src_b), .kind(op_sel[1:0]), .wide(lane32),
        .half(half_mode), .mask(mask)
    );

    assign is_arith = (op_sel == OP_ADD) || (op_sel == OP_SUB);
    assign is_cmp   = op_sel[2];

    // Form the next data and integer words from the decoded operation.
    always_comb begin
        nxt_data = dst_prev;
        nxt_int  = '0;
        if (is_arith) begin
            nxt_data = half_mode ? {dst_prev[DATA_W-1:HALF_W], sum[HALF_W-1:0]} : sum;
        end else if (is_cmp) begin
            nxt_int = {{(DATA_W-NSUB){1'b0}}, mask};
        end
    end

    // Result register: load on a valid strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            res_data  <= '0;
            res_int   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res_data <= nxt_data;
                res_int  <= nxt_int;
            end
        end
    end
endmodule

// File: rtl/simd_lane_alu_chk.sv
// Module: property checker for simd_lane_alu, attached by bind.
// Observes only the top-level ports. Assumes a synchronous active-low reset.
module simd_lane_alu_chk
    import simd_lane_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int SUB_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        op_sel,
    input logic              lane32,
    input logic              half_mode,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] src_b,
    input logic [DATA_W-1:0] dst_prev,
    input logic              out_valid,
    input logic [DATA_W-1:0] res_data,
    input logic [DATA_W-1:0] res_int
);
    localparam int NSUB   = DATA_W / SUB_W;
    localparam int HALF_W = DATA_W / 2;

    assert_valid_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(res_data) && $stable(res_int)));

    assert_upper_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && half_mode) |=> res_data[DATA_W-1:HALF_W] == $past(dst_prev[DATA_W-1:HALF_W]));

    assert_mask_high_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (lane32 || half_mode)) |=> res_int[DATA_W-1:NSUB/2] == '0);

    assert_cmp_data_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel[2]) |=> res_data == $past(dst_prev));

    assert_noncmp_int_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op_sel[2]) |=> res_int == '0);

    assert_eq_all_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == OP_CEQ && !lane32 && !half_mode && src_a == src_b)
        |=> res_int[NSUB-1:0] == {NSUB{1'b1}});
endmodule

bind simd_lane_alu simd_lane_alu_chk #(.DATA_W(DATA_W), .SUB_W(SUB_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .lane32(lane32), .half_mode(half_mode), .src_a(src_a), .src_b(src_b),
    .dst_prev(dst_prev), .out_valid(out_valid), .res_data(res_data),
    .res_int(res_int)
);

// File: tb/tb_simd_lane_alu.sv
// Bench: drives operations at the falling edge and compares every output
// with a behavioural lane model one cycle later.
module tb_simd_lane_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op_sel = 3'b000;
    logic        lane32 = 1'b0;
    logic        half_mode = 1'b0;
    logic [63:0] src_a = '0, src_b = '0, dst_prev = '0;
    logic        out_valid;
    logic [63:0] res_data, res_int;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [63:0] last_d = '0, last_i = '0;

    always #10 clk = ~clk;

    simd_lane_alu dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .lane32(lane32), .half_mode(half_mode), .src_a(src_a), .src_b(src_b),
        .dst_prev(dst_prev), .out_valid(out_valid), .res_data(res_data),
        .res_int(res_int)
    );

    // Behavioural reference: loops over lanes with integer arithmetic.
    task automatic model(input logic [2:0] op, input logic l32, input logic hf,
                         input logic [63:0] a, input logic [63:0] b, input logic [63:0] p,
                         output logic [63:0] d, output logic [63:0] iw);
        int w = l32 ? 32 : 16;
        int n = (hf ? 32 : 64) / w;
        logic [63:0] m = (64'd1 << w) - 64'd1;
        logic [63:0] sb = 64'd1 << (w - 1);
        d = p;
        iw = '0;
        for (int i = 0; i < n; i++) begin
            logic [63:0] la = (a >> (i*w)) & m;
            logic [63:0] lb = (b >> (i*w)) & m;
            longint sa = longint'(la ^ sb) - longint'(sb);
            longint sbv = longint'(lb ^ sb) - longint'(sb);
            logic [63:0] r;
            bit hit;
            if (op == 3'b000 || op == 3'b001) begin
                r = ((op == 3'b000) ? (la + lb) : (la - lb)) & m;
                d = (d & ~(m << (i*w))) | (r << (i*w));
            end else if (op[2]) begin
                case (op[1:0])
                    2'b00: hit = sa > sbv;
                    2'b01: hit = sa <= sbv;
                    2'b10: hit = sa == sbv;
                    default: hit = sa != sbv;
                endcase
                if (hit) iw[i] = 1'b1;
            end
        end
    endtask

    task automatic check(input string tag, input logic ev, input logic [63:0] ed,
                         input logic [63:0] ei);
        checks++;
        if (out_valid !== ev || res_data !== ed || res_int !== ei) begin
            failures++;
            $display("FAIL %s: got v=%0b d=%h i=%h expected v=%0b d=%h i=%h",
                     tag, out_valid, res_data, res_int, ev, ed, ei);
        end
    endtask

    task automatic run(input string tag, input logic [2:0] op, input logic l32,
                       input logic hf, input logic [63:0] a, input logic [63:0] b,
                       input logic [63:0] p);
        logic [63:0] ed, ei;
        @(negedge clk);
        op_sel = op; lane32 = l32; half_mode = hf;
        src_a = a; src_b = b; dst_prev = p; in_valid = 1'b1;
        model(op, l32, hf, a, b, p, ed, ei);
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, 1'b1, ed, ei);
        last_d = ed; last_i = ei;
    endtask

    initial begin
        // R8: reset state
        repeat (3) @(negedge clk);
        check("R8 reset", 1'b0, 64'h0, 64'h0);
        rst_n = 1'b1;

        // R1: 16-bit lane wrap with no carry crossing
        run("R1 add16 wrap", 3'b000, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0001_0001_0001, 64'h0);
        run("R1 sub16 borrow", 3'b001, 0, 0, 64'h0000_0000_0000_0000, 64'h0001_0002_0003_0004, 64'h0);
        // R2: 32-bit lanes carry across bit 16
        run("R2 add32 carry", 3'b000, 1, 0, 64'h0000_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, 64'h0);
        run("R2 sub32", 3'b001, 1, 0, 64'h0001_0000_0000_0000, 64'h0000_0001_0000_0001, 64'h0);
        // R3: reduced width keeps upper half of dst_prev
        run("R3 half add16", 3'b000, 0, 1, 64'h1111_2222_FFFF_0001, 64'h1111_1111_0001_FFFF, 64'hDEAD_BEEF_0BAD_F00D);
        run("R3 half sub32", 3'b001, 1, 1, 64'h5555_5555_0000_0000, 64'h1234_5678_0000_0001, 64'hCAFE_BABE_1234_5678);
        // R5: signed boundary, 0x7FFF vs 0x8000
        run("R5 gt16 signed", 3'b100, 0, 0, 64'h7FFF_8000_0001_FFFF, 64'h8000_7FFF_0001_0000, 64'hAAAA_AAAA_AAAA_AAAA);
        run("R5 le16 signed", 3'b101, 0, 0, 64'h7FFF_8000_0001_FFFF, 64'h8000_7FFF_0001_0000, 64'h0);
        run("R5 eq16", 3'b110, 0, 0, 64'h1234_0000_5678_9ABC, 64'h1234_0001_5678_9ABC, 64'h0);
        run("R5 ne32", 3'b111, 1, 0, 64'h0000_0001_8000_0000, 64'h0000_0001_7FFF_FFFF, 64'h0);
        run("R5 gt32 signed", 3'b100, 1, 0, 64'h8000_0000_7FFF_FFFF, 64'h7FFF_FFFF_8000_0000, 64'h0);
        // R4: mask widths per mode
        run("R4 eq16 full mask", 3'b110, 0, 0, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, 64'h0);
        run("R4 eq32 full mask", 3'b110, 1, 0, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, 64'h0);
        run("R4 eq16 half mask", 3'b110, 0, 1, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, 64'h0);
        run("R4 ne32 half mask", 3'b111, 1, 1, 64'h0000_0000_0000_0001, 64'h0, 64'h0);
        // R6/R9: data kept for compare, integer zero for reserved codes
        run("R6 cmp keeps data", 3'b111, 0, 0, 64'h1, 64'h2, 64'h0F0F_0F0F_0F0F_0F0F);
        run("R9 reserved 010", 3'b010, 0, 0, 64'hFFFF, 64'h1, 64'h1357_9BDF_2468_ACE0);
        run("R9 reserved 011", 3'b011, 1, 1, 64'hFFFF, 64'h1, 64'h0246_8ACE_1357_9BDF);

        // R7: idle cycles hold results, out_valid low
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            src_a = {$urandom, $urandom}; op_sel = 3'b000;
            check("R7 idle hold", 1'b0, last_d, last_i);
        end

        // Random sweep against the model
        for (int k = 0; k < 400; k++) begin
            logic [2:0] op = 3'($urandom);
            logic l32 = 1'($urandom);
            logic hf = 1'($urandom);
            logic [63:0] a = {$urandom, $urandom};
            logic [63:0] b = ($urandom % 4 == 0) ? a ^ (64'h1 << ($urandom % 64)) : {$urandom, $urandom};
            string tag = op[2] ? "R5 random cmp" : (op[1] ? "R9 random rsv" :
                         (hf ? "R3 random half" : (l32 ? "R2 random" : "R1 random")));
            run(tag, op, l32, hf, a, b, {$urandom, $urandom});
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule